// File: doc/BRIEF.md
# Multi-Port Queue Payload Dispatcher

This block steers address or data payloads from several valid/ready access ports into the entries of a load or store queue. Each queue entry is bound to exactly one port through an integer port index. An entry is waiting for its payload when it is allocated and its payload slot is still empty. The block is purely combinational. It tells every port whether some entry is waiting for it, and it presents each entry with the payload of the port it is bound to. It asserts a write enable for the entry that should take that payload in the current cycle.

Several waiting entries may be bound to the same port. When that port is valid, only the entry closest to the queue head, counting forward with wraparound, is written. Ports are resolved independently, so different ports can write different entries in the same cycle. The logic outside the block sets an entry's valid flag after a write, and that flag then removes the entry from the waiting set.

Top module: `pqd_dispatcher`

## Requirements
- R1: An entry is waiting only when its allocated flag is 1 and its payload-valid flag is 0. A non-waiting entry never receives a write enable and never contributes to any port's ready.
- R2: Every entry's payload output always equals the payload of the port given by its port index, whether or not a write occurs. Entry e uses payload bits [e*PAYLOAD_WIDTH +: PAYLOAD_WIDTH] and index bits [e*IDX_W +: IDX_W]; port p uses payload bits [p*PAYLOAD_WIDTH +: PAYLOAD_WIDTH].
- R3: A port index of N_PORTS or larger selects no port. That entry's payload output is all zeros, and it never requests a port or receives a write enable.
- R4: Port p's ready output is 1 exactly when at least one waiting entry has port index p.
- R5: No write enable is asserted for an entry whose port has its valid input at 0.
- R6: For each port, at most one entry is written per cycle. That entry is the first waiting, valid-port entry found by scanning from the head entry upward, wrapping from N_ENTRIES-1 to 0.
- R7: Ports are arbitrated independently. In a single cycle every port that is valid and has a waiting entry writes one entry.
- R8: The head position is the lowest set bit of the head vector. An all-zero head vector starts the scan at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| port_payload_i | input | N_PORTS*PAYLOAD_WIDTH | Payload offered by each port |
| port_valid_i | input | N_PORTS | Valid flag of each port |
| port_ready_o | output | N_PORTS | Ready flag returned to each port |
| entry_alloc_i | input | N_ENTRIES | Entry is allocated |
| entry_filled_i | input | N_ENTRIES | Entry payload slot already valid |
| entry_port_i | input | N_ENTRIES*IDX_W | Port index bound to each entry |
| queue_head_i | input | N_ENTRIES | One-hot position of the oldest entry |
| entry_payload_o | output | N_ENTRIES*PAYLOAD_WIDTH | Payload routed to each entry |
| entry_wen_o | output | N_ENTRIES | Write enable of each entry |

## Verification
The block holds no state, so a fault in any internal stage shows at the ports in the same cycle as the inputs that expose it. A broken decode shows as a wrong payload or a wrong ready bit. A faulty waiting mask shows as ready asserted, or an entry written, for an allocated-and-filled or unallocated entry. An arbitration fault shows as two writes for one port, or as a younger entry written ahead of an older one. Directed vectors cover the wraparound scan, an all-zero head, out-of-range indices and invalid ports. A long random run then compares every output against an independent model each cycle.

// File: rtl/pqd_pkg.sv
package pqd_pkg;

  // Width of a port index: at least one bit even for a single port.
  function automatic int idx_width(input int n_ports);
    return (n_ports > 1) ? $clog2(n_ports) : 1;
  endfunction

endpackage

// File: rtl/pqd_entry_route.sv
module pqd_entry_route #(
  parameter int N_PORTS       = 3,
  parameter int PAYLOAD_WIDTH = 16,
  parameter int IDX_W         = 2
) (
  input  logic [N_PORTS*PAYLOAD_WIDTH-1:0] port_payload,
  input  logic [IDX_W-1:0]                 port_idx,
  input  logic                             waiting,
  output logic [N_PORTS-1:0]               want,
  output logic [PAYLOAD_WIDTH-1:0]         payload
);

  logic [N_PORTS-1:0] sel_oh;

  // Integer index to one-hot; out-of-range values select nothing.
  always_comb begin
    sel_oh = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (port_idx == IDX_W'(p)) sel_oh[p] = 1'b1;
    end
    assert_onehot_sel_R3: assert ($onehot0(sel_oh))
      else $error("decoded port select is not one-hot");
  end

  // One-hot payload mux.
  always_comb begin
    payload = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (sel_oh[p]) payload = payload | port_payload[p*PAYLOAD_WIDTH +: PAYLOAD_WIDTH];
    end
  end

  // Port request only while the entry waits.
  always_comb begin
    want = sel_oh & {N_PORTS{waiting}};
  end

endmodule

// File: rtl/pqd_age_arbiter.sv
module pqd_age_arbiter #(
  parameter int N_ENTRIES = 8
) (
  input  logic [N_ENTRIES-1:0] req,
  input  logic [N_ENTRIES-1:0] head_oh,
  output logic [N_ENTRIES-1:0] grant
);

  int  start_pos;
  int  pos;
  logic head_seen;
  logic taken;

  // Scan forward from the head with wraparound; first request wins.
  always_comb begin
    start_pos = 0;
    head_seen = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!head_seen && head_oh[i]) begin
        start_pos = i;
        head_seen = 1'b1;
      end
    end
    grant = '0;
    taken = 1'b0;
    pos   = 0;
    for (int k = 0; k < N_ENTRIES; k++) begin
      pos = (start_pos + k) % N_ENTRIES;
      if (!taken && req[pos]) begin
        grant[pos] = 1'b1;
        taken      = 1'b1;
      end
    end
    assert_single_grant_R6: assert ($onehot0(grant))
      else $error("more than one grant for a port");
    assert_grant_requested_R5: assert ((grant & ~req) == '0)
      else $error("grant without a request");
    assert_grant_when_req_R7: assert ((req == '0) == (grant == '0))
      else $error("requests present but no grant");
  end

endmodule

// File: rtl/pqd_dispatcher.sv
module pqd_dispatcher #(
  parameter int N_PORTS       = 3,
  parameter int N_ENTRIES     = 8,
  parameter int PAYLOAD_WIDTH = 16,
  parameter int IDX_W         = pqd_pkg::idx_width(N_PORTS)
) (
  input  logic [N_PORTS*PAYLOAD_WIDTH-1:0]   port_payload_i,
  input  logic [N_PORTS-1:0]                 port_valid_i,
  output logic [N_PORTS-1:0]                 port_ready_o,
  input  logic [N_ENTRIES-1:0]               entry_alloc_i,
  input  logic [N_ENTRIES-1:0]               entry_filled_i,
  input  logic [N_ENTRIES*IDX_W-1:0]         entry_port_i,
  input  logic [N_ENTRIES-1:0]               queue_head_i,
  output logic [N_ENTRIES*PAYLOAD_WIDTH-1:0] entry_payload_o,
  output logic [N_ENTRIES-1:0]               entry_wen_o
);

  logic [N_ENTRIES-1:0] waiting;
  logic [N_PORTS-1:0]   want_m  [N_ENTRIES];
  logic [N_ENTRIES-1:0] opt_col [N_PORTS];
  logic [N_ENTRIES-1:0] gnt_col [N_PORTS];

  always_comb begin
    waiting = entry_alloc_i & ~entry_filled_i;
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    pqd_entry_route #(
      .N_PORTS      (N_PORTS),
      .PAYLOAD_WIDTH(PAYLOAD_WIDTH),
      .IDX_W        (IDX_W)
    ) u_route (
      .port_payload(port_payload_i),
      .port_idx    (entry_port_i[e*IDX_W +: IDX_W]),
      .waiting     (waiting[e]),
      .want        (want_m[e]),
      .payload     (entry_payload_o[e*PAYLOAD_WIDTH +: PAYLOAD_WIDTH])
    );
  end

  // Handshake: ready per port, then mask requests by port valid.
  always_comb begin
    port_ready_o = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      opt_col[p] = '0;
      for (int e = 0; e < N_ENTRIES; e++) begin
        port_ready_o[p] = port_ready_o[p] | want_m[e][p];
        opt_col[p][e]   = want_m[e][p] & port_valid_i[p];
      end
      assert_opt_implies_ready_R4: assert ((opt_col[p] == '0) || port_ready_o[p])
        else $error("handshaked request on a port that is not ready");
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    pqd_age_arbiter #(
      .N_ENTRIES(N_ENTRIES)
    ) u_arb (
      .req    (opt_col[p]),
      .head_oh(queue_head_i),
      .grant  (gnt_col[p])
    );
  end

  always_comb begin
    entry_wen_o = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      entry_wen_o = entry_wen_o | gnt_col[p];
    end
  end

endmodule

// File: tb/tb_pqd_dispatcher.sv
module tb_pqd_dispatcher;
  localparam int NP = 3;
  localparam int NE = 8;
  localparam int W  = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP*W-1:0]  port_payload;
  logic [NP-1:0]    port_valid;
  logic [NP-1:0]    port_ready;
  logic [NE-1:0]    alloc, filled, head;
  logic [NE*IW-1:0] pidx;
  logic [NE*W-1:0]  epay;
  logic [NE-1:0]    wen;

  pqd_dispatcher #(.N_PORTS(NP), .N_ENTRIES(NE), .PAYLOAD_WIDTH(W)) dut (
    .port_payload_i(port_payload), .port_valid_i(port_valid), .port_ready_o(port_ready),
    .entry_alloc_i(alloc), .entry_filled_i(filled), .entry_port_i(pidx),
    .queue_head_i(head), .entry_payload_o(epay), .entry_wen_o(wen)
  );

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  logic [NP-1:0]   q_ready [$];
  logic [NE-1:0]   q_wen   [$];
  logic [NE*W-1:0] q_pay   [$];
  string           q_tag   [$];

  int ix [NE];

  // Driver: apply one vector at the falling edge and push the model result.
  task automatic apply(input logic [NE-1:0] a, input logic [NE-1:0] f,
                       input logic [NE-1:0] h, input logic [NP-1:0] v,
                       input logic [NP*W-1:0] pl, input string tag);
    logic [NP-1:0]   er;
    logic [NE-1:0]   ew;
    logic [NE*W-1:0] ep;
    logic [NE*IW-1:0] pk;
    int start;
    @(negedge clk);
    pk = '0;
    for (int e = 0; e < NE; e++) pk[e*IW +: IW] = IW'(ix[e]);
    alloc = a; filled = f; head = h; port_valid = v; port_payload = pl; pidx = pk;
    er = '0; ew = '0; ep = '0;
    for (int e = 0; e < NE; e++) begin
      if (ix[e] < NP) begin
        ep[e*W +: W] = pl[ix[e]*W +: W];
        if (a[e] && !f[e]) er[ix[e]] = 1'b1;
      end
    end
    start = 0;
    for (int e = NE-1; e >= 0; e--) if (h[e]) start = e;
    for (int p = 0; p < NP; p++) begin
      if (v[p]) begin
        for (int k = 0; k < NE; k++) begin
          int e2;
          e2 = (start + k) % NE;
          if (a[e2] && !f[e2] && ix[e2] == p) begin
            ew[e2] = 1'b1;
            break;
          end
        end
      end
    end
    q_ready.push_back(er); q_wen.push_back(ew); q_pay.push_back(ep); q_tag.push_back(tag);
  endtask

  // Monitor: pop and compare at the rising edge, half a period after the drive.
  always @(posedge clk) begin
    if (q_ready.size() > 0) begin
      logic [NP-1:0] er; logic [NE-1:0] ew; logic [NE*W-1:0] ep; string t;
      er = q_ready.pop_front(); ew = q_wen.pop_front(); ep = q_pay.pop_front(); t = q_tag.pop_front();
      checks += 3;
      if (port_ready !== er) begin
        fails++; $display("FAIL %s ready (R4): got %b expected %b", t, port_ready, er);
      end
      if (wen !== ew) begin
        fails++; $display("FAIL %s write enable (R6): got %b expected %b", t, wen, ew);
      end
      if (epay !== ep) begin
        fails++; $display("FAIL %s payload (R2): got %h expected %h", t, epay, ep);
      end
    end
  end

  localparam logic [NP*W-1:0] PL = {16'h2020, 16'hF8F8, 16'h6F6F};

  initial begin
    alloc = '0; filled = '0; head = '0; port_valid = '0; port_payload = '0; pidx = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: idle inputs give no ready, no write, port 0 payload (zero).
    for (int e = 0; e < NE; e++) ix[e] = 0;
    apply('0, '0, '0, '0, '0, "R2 idle");
    // R1: only allocated, unfilled entries wait; entry 2 is head.
    ix[0] = 1; ix[1] = 0; ix[2] = 1; ix[3] = 2;
    apply(8'b0000_1101, 8'b0000_0100, 8'b0000_0100, 3'b111, PL, "R1 mask");
    apply(8'b0000_1101, 8'b0000_0000, 8'b0000_0100, 3'b111, PL, "R1 head");
    // R6: wraparound, entries 1,5,6 on port 0, head 6 -> 6; head 7 -> 1.
    for (int e = 0; e < NE; e++) ix[e] = 1;
    ix[1] = 0; ix[5] = 0; ix[6] = 0;
    apply(8'b0110_0010, '0, 8'b0100_0000, 3'b001, PL, "R6 head6");
    apply(8'b0110_0010, '0, 8'b1000_0000, 3'b001, PL, "R6 wrap");
    // R5: port 0 not valid -> ready but no write.
    apply(8'b0110_0010, '0, 8'b0000_0010, 3'b110, PL, "R5 invalid");
    // R7: every port has waiting entries, all valid -> three writes.
    for (int e = 0; e < NE; e++) ix[e] = e % NP;
    apply(8'hFF, 8'b0000_0001, 8'b0001_0000, 3'b111, PL, "R7 parallel");
    // R3: index 3 is out of range: zero payload, no request.
    for (int e = 0; e < NE; e++) ix[e] = 3;
    ix[2] = 2;
    apply(8'hFF, '0, 8'b0000_0001, 3'b111, PL, "R3 range");
    // R8: zero head scans from entry 0; two head bits use the lowest.
    for (int e = 0; e < NE; e++) ix[e] = 1;
    apply(8'b1010_0000, '0, '0, 3'b010, PL, "R8 zero head");
    apply(8'b1010_0100, '0, 8'b1000_1000, 3'b010, PL, "R8 multi head");
    // Random patterns.
    for (int n = 0; n < 400; n++) begin
      logic [NP*W-1:0] rp;
      for (int e = 0; e < NE; e++) ix[e] = int'($urandom_range(0, 3));
      for (int p = 0; p < NP; p++) rp[p*W +: W] = W'($urandom);
      apply(NE'($urandom), NE'($urandom), NE'(1) << $urandom_range(0, NE-1),
            NP'($urandom), rp, "R4 random");
    end
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule